// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Programming Controller

This block holds a behavioural model of a byte-wide programmable memory together with the control logic that writes and checks it. Three active-low strobes (program, latch, verify) choose what the block does with the shared data bus. It can burn a byte, drive the stored byte back for checking, or stay quiet. Programming can only turn bits on: each write ORs the bus byte into the addressed cell. Only the erase input returns cells to zero.

One location sits just above the data space. It holds a configuration byte. Bit 0 of that byte picks how the normal read path treats its output enable. With bit 0 clear the enable acts at once. With bit 0 set the enable is captured on the clock edge, like the read data.

A blank-check scan walks every location, the configuration byte included, at one location per clock. It then reports whether all of them are zero. The data space holds 2**ADDR_W bytes, and the configuration byte lives at programming address 2**ADDR_W.

Top module: `prom_prog_ctrl`

## Requirements
- R1: With prog_n=0, latch_n=0 and vfy_n=1 (program), the rising clock edge ORs data_in into the location selected by addr.
- R2: A program operation never clears a stored bit: after writing any byte D over stored value S, the location holds S|D.
- R3: With prog_n=1, latch_n=0 and vfy_n=0 (verify), data_oe is 1 and data_out shows the stored byte at addr in the same cycle. Erased locations read 0x00.
- R4: Every other strobe pattern, including prog_n=1, latch_n=0, vfy_n=1, acts as inhibit: data_oe is 0 and no location changes.
- R5: Address 2**ADDR_W selects the configuration byte, which can be programmed and verified like data. Any address above it is ignored for writes and verifies as 0x00.
- R6: erase=1 at a clock edge sets every location to zero, the configuration byte included, and wins over a program in the same cycle.
- R7: A blank_start pulse while idle holds blank_busy high for exactly 2**ADDR_W+1 cycles. blank_ok then reads 1 only if every location is zero. A blank_start pulse while busy has no effect.
- R8: rd_data is registered: after each rising edge it holds the data byte at the rd_addr sampled at that edge.
- R9: While bit 0 of the configuration byte is 0, rd_oe equals !rd_en_n combinationally.
- R10: While bit 0 of the configuration byte is 1, rd_oe equals !rd_en_n as sampled at the previous rising edge.
- R11: After reset all locations are zero, rd_data is 0x00, blank_busy and blank_ok are 0, and data_oe is 0 under inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_n | input | 1 | Program strobe, active low |
| latch_n | input | 1 | Latch strobe, active low |
| vfy_n | input | 1 | Verify strobe, active low |
| addr | input | ADDR_W+1 | Programming address; value 2**ADDR_W is the configuration byte |
| data_in | input | 8 | Bus byte to burn |
| data_out | output | 8 | Byte driven back in verify |
| data_oe | output | 1 | High while the block drives the bus |
| erase | input | 1 | Clear every location |
| blank_start | input | 1 | Start a blank-check scan |
| blank_busy | output | 1 | Scan in progress |
| blank_ok | output | 1 | Last scan found every location zero |
| rd_addr | input | ADDR_W | Read-path address |
| rd_en_n | input | 1 | Read-path output enable, active low |
| rd_data | output | 8 | Registered read data |
| rd_oe | output | 1 | Read-path output enable after the mode selection |

## Verification
A corrupted cell appears at data_out on the next verify of that address, in the same cycle. It also shows in rd_data one edge after that address is selected on the read path. A wrong configuration bit shows at once: rd_oe either follows rd_en_n without delay or lags it by one edge. A faulty scan counter or accumulator is caught when busy falls, because the busy length and blank_ok are known exactly after 2**ADDR_W+1 cycles. Sweeping every address and every strobe pattern in a 16-byte configuration exposes a bad decode or a wrong index within a single pass.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_INHIBIT = 2'd0,
        MODE_PROGRAM = 2'd1,
        MODE_VERIFY  = 2'd2
    } prog_mode_e;

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
    import prom_prog_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              prog_n,
    input  logic              latch_n,
    input  logic              vfy_n,
    input  logic [ADDR_W:0]   addr,
    output prog_mode_e        mode,
    output logic              loc_ok
);

    // Only two strobe patterns are active; everything else inhibits.
    always_comb begin
        mode = MODE_INHIBIT;
        if (!latch_n) begin
            if (!prog_n && vfy_n)
                mode = MODE_PROGRAM;
            else if (prog_n && !vfy_n)
                mode = MODE_VERIFY;
        end
    end

    // Valid: any data address, or exactly the configuration slot.
    assign loc_ok = !addr[ADDR_W] || (addr[ADDR_W-1:0] == '0);

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array
    import prom_prog_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NRD    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         erase,
    input  logic                         wr_en,
    input  logic [ADDR_W:0]              wr_idx,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic [NRD-1:0][ADDR_W:0]     rd_idx,
    output logic [NRD-1:0][BYTE_W-1:0]   rd_data,
    output logic                         cfg_bit0
);

    localparam int DEPTH = (1 << ADDR_W) + 1;
    localparam int IDX_W = ADDR_W + 1;

    logic [BYTE_W-1:0] cell_q [DEPTH];
    logic [BYTE_W-1:0] cell_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase)
                cell_d[i] = '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                cell_d[i] = cell_q[i] | wr_data;
            else
                cell_d[i] = cell_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= cell_d[i];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (rd_idx[p] == IDX_W'(i)) rd_data[p] = cell_q[i];
            end
        end
    end

    assign cfg_bit0 = cell_q[DEPTH-1][0];

endmodule

// File: rtl/prom_blank_scan.sv
module prom_blank_scan
    import prom_prog_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [ADDR_W:0]    cell_idx,
    input  logic [BYTE_W-1:0]  cell_data,
    output logic               busy,
    output logic               ok
);

    localparam int IDX_W = ADDR_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(1 << ADDR_W);

    typedef struct packed {
        logic             busy;
        logic             ok;
        logic             dirty;
        logic [IDX_W-1:0] idx;
    } scan_t;

    scan_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.ok    = 1'b0;
                s_d.dirty = 1'b0;
                s_d.idx   = '0;
            end
        end else begin
            s_d.dirty = s_q.dirty | (cell_data != '0);
            if (s_q.idx == LAST_IDX) begin
                s_d.busy = 1'b0;
                s_d.ok   = !s_d.dirty;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cell_idx = s_q.idx;
    assign busy     = s_q.busy;
    assign ok       = s_q.ok;

endmodule

// File: rtl/prom_prog_ctrl.sv
module prom_prog_ctrl
    import prom_prog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_n,
    input  logic                latch_n,
    input  logic                vfy_n,
    input  logic [ADDR_W:0]     addr,
    input  logic [7:0]          data_in,
    output logic [7:0]          data_out,
    output logic                data_oe,
    input  logic                erase,
    input  logic                blank_start,
    output logic                blank_busy,
    output logic                blank_ok,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_en_n,
    output logic [7:0]          rd_data,
    output logic                rd_oe
);

    localparam int NRD     = 3;
    localparam int PORT_PV = 0;
    localparam int PORT_SC = 1;
    localparam int PORT_RD = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              oe;
    } rd_path_t;

    prog_mode_e                     mode;
    logic                           loc_ok;
    logic [NRD-1:0][ADDR_W:0]       rd_idx;
    logic [NRD-1:0][BYTE_W-1:0]     rd_bytes;
    logic [ADDR_W:0]                scan_idx;
    logic                           arch_sync;
    rd_path_t                       rp_q, rp_d;

    prom_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
        .prog_n  (prog_n),
        .latch_n (latch_n),
        .vfy_n   (vfy_n),
        .addr    (addr),
        .mode    (mode),
        .loc_ok  (loc_ok)
    );

    assign rd_idx[PORT_PV] = addr;
    assign rd_idx[PORT_SC] = scan_idx;
    assign rd_idx[PORT_RD] = {1'b0, rd_addr};

    prom_cell_array #(.ADDR_W(ADDR_W), .NRD(NRD)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase    (erase),
        .wr_en    ((mode == MODE_PROGRAM) && loc_ok),
        .wr_idx   (addr),
        .wr_data  (data_in),
        .rd_idx   (rd_idx),
        .rd_data  (rd_bytes),
        .cfg_bit0 (arch_sync)
    );

    prom_blank_scan #(.ADDR_W(ADDR_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (blank_start),
        .cell_idx  (scan_idx),
        .cell_data (rd_bytes[PORT_SC]),
        .busy      (blank_busy),
        .ok        (blank_ok)
    );

    // Programming bus: drive only in verify; out-of-range reads as zero.
    always_comb begin
        data_oe  = (mode == MODE_VERIFY);
        data_out = (data_oe && loc_ok) ? rd_bytes[PORT_PV] : '0;
    end

    // Normal read path: data always registered, enable registered or not.
    always_comb begin
        rp_d      = rp_q;
        rp_d.data = rd_bytes[PORT_RD];
        rp_d.oe   = !rd_en_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign rd_data = rp_q.data;
    assign rd_oe   = arch_sync ? rp_q.oe : !rd_en_n;

endmodule

// File: rtl/prom_prog_chk.sv
module prom_prog_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_n,
    input logic              latch_n,
    input logic              vfy_n,
    input logic [ADDR_W:0]   addr,
    input logic [7:0]        data_in,
    input logic [7:0]        data_out,
    input logic              data_oe,
    input logic              erase,
    input logic              blank_busy,
    input logic              rd_en_n,
    input logic              rd_oe,
    input logic              arch_sync
);

    localparam int DEPTH = (1 << ADDR_W) + 1;

    logic        is_prog, is_vfy;
    logic        live_q;
    logic [31:0] busy_cnt_q;

    assign is_prog = !prog_n && !latch_n && vfy_n;
    assign is_vfy  = prog_n && !latch_n && !vfy_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q     <= 1'b0;
            busy_cnt_q <= '0;
        end else begin
            live_q     <= 1'b1;
            busy_cnt_q <= blank_busy ? busy_cnt_q + 1 : '0;
        end
    end

    p_verify_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_vfy |-> data_oe);

    p_inhibit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_vfy |-> !data_oe);

    p_program_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(is_prog) && !$past(erase) && is_vfy
         && addr == $past(addr) && !addr[ADDR_W])
        |-> ((data_out & $past(data_in)) == $past(data_in)));

    p_erase_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(erase) && is_vfy) |-> (data_out == 8'h00));

    p_blank_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $fell(blank_busy)) |-> (busy_cnt_q == 32'(DEPTH)));

    p_sync_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && arch_sync && $past(arch_sync)) |-> (rd_oe == !$past(rd_en_n)));

endmodule

bind prom_prog_ctrl prom_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_n     (prog_n),
    .latch_n    (latch_n),
    .vfy_n      (vfy_n),
    .addr       (addr),
    .data_in    (data_in),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .erase      (erase),
    .blank_busy (blank_busy),
    .rd_en_n    (rd_en_n),
    .rd_oe      (rd_oe),
    .arch_sync  (arch_sync)
);

// File: tb/tb_prom_prog_ctrl.sv
module tb_prom_prog_ctrl;

    localparam int AW    = 4;
    localparam int NDATA = 1 << AW;
    localparam int DEPTH = NDATA + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_n = 1'b1, latch_n = 1'b0, vfy_n = 1'b1;
    logic [AW:0]   addr = '0;
    logic [7:0]    data_in = '0;
    logic [7:0]    data_out;
    logic          data_oe;
    logic          erase = 1'b0;
    logic          blank_start = 1'b0;
    logic          blank_busy, blank_ok;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_en_n = 1'b1;
    logic [7:0]    rd_data;
    logic          rd_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int model [DEPTH];

    always #5 clk = ~clk;

    prom_prog_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .latch_n(latch_n),
        .vfy_n(vfy_n), .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .erase(erase), .blank_start(blank_start),
        .blank_busy(blank_busy), .blank_ok(blank_ok), .rd_addr(rd_addr),
        .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic burn(input int a, input int d);
        prog_n = 1'b0; latch_n = 1'b0; vfy_n = 1'b1;
        addr = (AW+1)'(a); data_in = 8'(d);
        tick();
        prog_n = 1'b1;
    endtask

    task automatic peek(input int a, output int v, output int oe);
        prog_n = 1'b1; latch_n = 1'b0; vfy_n = 1'b0;
        addr = (AW+1)'(a);
        #1;
        v = data_out; oe = data_oe;
        vfy_n = 1'b1;
        #1;
    endtask

    task automatic check_all(input string req);
        int v, oe;
        for (int i = 0; i < DEPTH; i++) begin
            peek(i, v, oe);
            check(req, v, model[i]);
        end
    endtask

    task automatic blank_run(input int exp_ok);
        int cnt = 0;
        blank_start = 1'b1;
        tick();
        blank_start = 1'b0;
        while (blank_busy && cnt < 100) begin
            if (cnt == 4) blank_start = 1'b1;   // R7: ignored while busy
            tick();
            blank_start = 1'b0;
            cnt++;
        end
        check("R7 scan length", cnt, DEPTH);
        check("R7 blank result", int'(blank_ok), exp_ok);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, oe;
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R11: reset state
        check("R11 rd_data", int'(rd_data), 0);
        check("R11 blank_busy", int'(blank_busy), 0);
        check("R11 blank_ok", int'(blank_ok), 0);
        check("R11 data_oe inhibit", int'(data_oe), 0);

        // R7, R3: blank after reset, erased reads zero
        blank_run(1);
        check_all("R3 erased readback");

        // R1, R3: program a pattern and verify
        for (int i = 0; i < NDATA; i++) begin
            model[i] = (i * 37 + 5) & 8'hFF;
            burn(i, model[i]);
        end
        check_all("R1 pattern verify");
        peek(3, v, oe);
        check("R3 verify oe", oe, 1);

        // R2: attempts to clear bits only OR in new ones
        for (int i = 0; i < NDATA; i++) begin
            int d = (~(i * 11 + 3)) & 8'hFF;
            burn(i, d);
            model[i] = model[i] | d;
        end
        burn(7, 0);
        check_all("R2 no bit cleared");

        // R4: every non-program strobe pattern inhibits
        for (int p = 0; p < 8; p++) begin
            if (p == 1) continue;
            prog_n = p[2]; latch_n = p[1]; vfy_n = p[0];
            addr = (AW+1)'(p); data_in = 8'hFF;
            tick();
            check("R4 data_oe per pattern", int'(data_oe), (p == 4) ? 1 : 0);
        end
        prog_n = 1'b1; latch_n = 1'b0; vfy_n = 1'b1;
        check_all("R4 inhibit left cells unchanged");

        // R5: addresses above the configuration slot are ignored
        for (int a = NDATA + 1; a < 2 * NDATA; a++) burn(a, 8'hFF);
        check_all("R5 out-of-range write ignored");
        peek(NDATA + 5, v, oe);
        check("R5 out-of-range verify", v, 0);

        // R8, R9: read path in immediate-enable mode
        for (int i = 0; i < NDATA; i++) begin
            rd_addr = AW'(i);
            tick();
            check("R8 rd_data", int'(rd_data), model[i]);
        end
        rd_en_n = 1'b0; #1;
        check("R9 rd_oe immediate on", int'(rd_oe), 1);
        rd_en_n = 1'b1; #1;
        check("R9 rd_oe immediate off", int'(rd_oe), 0);

        // R7: scan detects programmed content
        blank_run(0);

        // R5, R10: program configuration bit, enable becomes clocked
        burn(NDATA, 8'h01);
        model[NDATA] = 1;
        peek(NDATA, v, oe);
        check("R5 config verify", v, 1);
        tick();
        rd_en_n = 1'b0; #1;
        check("R10 rd_oe holds before edge", int'(rd_oe), 0);
        tick();
        check("R10 rd_oe after edge", int'(rd_oe), 1);
        rd_en_n = 1'b1; #1;
        check("R10 rd_oe holds high", int'(rd_oe), 1);
        tick();
        check("R10 rd_oe falls after edge", int'(rd_oe), 0);

        // R6: erase beats a simultaneous program
        erase = 1'b1;
        burn(2, 8'hFF);
        erase = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        check_all("R6 erase clears all");
        rd_en_n = 1'b0; #1;
        check("R6 config cleared, enable immediate", int'(rd_oe), 1);
        rd_en_n = 1'b1;
        blank_run(1);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule